// File: doc/BRIEF.md
# Sin/Cos Encoder Position Evaluator

This block turns digitised sine and cosine samples from an analog incremental encoder into a high-resolution position. Each incoming sample pair is first corrected for offset and gain on each channel separately. The corrected values then feed two paths. In the first, a greater-than-zero comparator on each channel yields two quadrature levels, and a quadrature decoder moves a wrapping up/down counter once for every zero crossing. In the second, an arctangent of the pair gives the angle inside the current quarter period.

The coarse count and the fine angle are merged into one position word. The two paths can briefly disagree next to an axis: the comparator treats zero as negative, while the arctangent places zero at the start of a quadrant. When that happens the counter is trusted and the fine angle is clamped to the edge of the counter's quadrant. A sample where both comparator levels flip together cannot be decoded. It leaves the count untouched and raises a sticky error flag.

The number of sine periods per revolution is the parameter `PERIODS`. The counter wraps modulo four times that value, so one revolution covers `4*PERIODS` counts of `2^FINE_W` fine steps each. The arctangent uses a table of one octant, indexed by the ratio of the smaller to the larger magnitude, and folds it to the full circle.

Top module: `sincos_pos_eval`

## Requirements
- R1: The correction for each channel is `floor((raw - offset) * gain / 2^GAIN_FRAC)`, saturated to the symmetric range ±(2^(ADC_W-1)-1). The gain is unsigned, and 2^GAIN_FRAC means unity. The corrected register never holds the most negative code.
- R2: Each corrected channel becomes a level that is 1 when the value is strictly greater than zero. The level pair (sin, cos) selects a decoder quadrant: 11→0, 10→1, 00→2, 01→3.
- R3: On each accepted sample, a quadrant step of +1 (mod 4) from the previous sample adds one to the count, a step of −1 subtracts one, and no change leaves the count as it is. While no error is flagged, the two low bits of the count equal the decoder quadrant of the last sample.
- R4: The count runs from 0 to 4*PERIODS−1. It wraps to 0 after the top value when stepping up, and to the top value after 0 when stepping down.
- R5: A step of 2 (both levels change) leaves the count unchanged and sets `quad_err_o`, which stays set until reset. The previous quadrant still takes the new value.
- R6: The arctangent quadrant k is the one whose rotated pair (x, y) has x>0 and y≥0, using (x,y)=(cos,sin) rotated by −90° k times; a pair that is all zero gives k=0 and fine 0. With N=2^IDX_W and H=2^(FINE_W−1), the table entry is T(i)=⌊i·H/N⌋+⌊89·H·i·(N−i)/(256·N²)⌋. The fine angle is T(⌊y·N/x⌋) when y≤x. Otherwise it is min(2^FINE_W−1, 2^FINE_W−T(⌊x·N/y⌋)).
- R7: Let d = (arctangent quadrant − new count) mod 4. If d=0 the fine output is the arctangent fine angle, if d=1 it is 2^FINE_W−1, and for d=2 or d=3 it is 0.
- R8: `pos_o` equals count·2^FINE_W + fine.
- R9: A sample strobed at edge n appears on the outputs at edge n+2, with `pos_valid_o` high for that one cycle. The outputs hold their values when no sample is processed.
- R10: After reset the count, the fine angle, the position, the error flag and `pos_valid_o` are all 0, and the previous quadrant is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample strobe for the sine/cosine pair |
| sin_raw_i | input | ADC_W | Signed raw sine sample |
| cos_raw_i | input | ADC_W | Signed raw cosine sample |
| sin_off_i | input | ADC_W | Signed sine offset |
| cos_off_i | input | ADC_W | Signed cosine offset |
| sin_gain_i | input | GAIN_W | Unsigned sine gain, unity = 2^GAIN_FRAC |
| cos_gain_i | input | GAIN_W | Unsigned cosine gain, unity = 2^GAIN_FRAC |
| pos_valid_o | output | 1 | One-cycle flag for new outputs |
| count_o | output | CNT_W | Quarter-period count |
| fine_o | output | FINE_W | Fine angle within the quarter period |
| pos_o | output | CNT_W+FINE_W | Merged position |
| quad_err_o | output | 1 | Sticky flag for an undecodable transition |

## Verification
The assertions take for granted that the calibration inputs stay fixed while a sample moves through the two pipeline stages. They also assume that, except where an error is provoked on purpose, successive samples never move more than one quadrant. The random angle walk keeps each step under 60 degrees and changes offsets and gains only between samples. The one step that crosses two quadrants is placed last and is followed by a reset.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_BAD  = 2'd3
  } qstep_e;

  // level pair (sin>0, cos>0) -> decoder quadrant
  function automatic logic [1:0] level_quadrant(input logic s_pos, input logic c_pos);
    case ({s_pos, c_pos})
      2'b11:   return 2'd0;
      2'b10:   return 2'd1;
      2'b00:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic qstep_e classify_step(input logic [1:0] prev, input logic [1:0] cur);
    logic [1:0] diff;
    diff = cur - prev;
    case (diff)
      2'd0:    return STEP_NONE;
      2'd1:    return STEP_UP;
      2'd3:    return STEP_DOWN;
      default: return STEP_BAD;
    endcase
  endfunction

  // octant arctangent approximation, scaled so that ratio 1 gives 'half'
  function automatic int unsigned octant_entry(input int unsigned i, input int unsigned idx_w,
                                               input int unsigned half);
    int unsigned n;
    n = 32'd1 << idx_w;
    return (i * half) / n + (89 * half * i * (n - i)) / (256 * n * n);
  endfunction

endpackage

// File: rtl/sc_corrector.sv
module sc_corrector #(
  parameter int ADC_W     = 12,
  parameter int GAIN_W    = 12,
  parameter int GAIN_FRAC = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid_i,
  input  logic signed [ADC_W-1:0]  raw_i,
  input  logic signed [ADC_W-1:0]  off_i,
  input  logic        [GAIN_W-1:0] gain_i,
  output logic signed [ADC_W-1:0]  corr_o
);
  localparam int DW  = ADC_W + 1;
  localparam int PW  = DW + GAIN_W + 1;
  localparam int LIM = (1 << (ADC_W - 1)) - 1;
  localparam logic signed [PW-1:0] LIM_HI = PW'(LIM);
  localparam logic signed [PW-1:0] LIM_LO = -LIM_HI;
  localparam logic [ADC_W-1:0] MOST_NEG = {1'b1, {(ADC_W-1){1'b0}}};

  logic signed [DW-1:0]    diff;
  logic signed [PW-1:0]    prod;
  logic signed [PW-1:0]    scaled;
  logic signed [ADC_W-1:0] corr_d;
  logic signed [ADC_W-1:0] corr_q;

  always_comb begin
    diff   = {raw_i[ADC_W-1], raw_i} - {off_i[ADC_W-1], off_i};
    prod   = diff * $signed({1'b0, gain_i});
    scaled = prod >>> GAIN_FRAC;
    if (scaled > LIM_HI)      corr_d = LIM_HI[ADC_W-1:0];
    else if (scaled < LIM_LO) corr_d = LIM_LO[ADC_W-1:0];
    else                      corr_d = scaled[ADC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          corr_q <= '0;
    else if (in_valid_i) corr_q <= corr_d;
  end

  assign corr_o = corr_q;

  AST_SAT_SYMMETRIC: assert property (@(posedge clk) disable iff (!rst_n)
    corr_q != MOST_NEG); // R1
  AST_CORR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> $stable(corr_q)); // R9

endmodule

// File: rtl/sc_quad_counter.sv
module sc_quad_counter
  import sincos_pkg::*;
#(
  parameter int PERIODS = 1000,
  parameter int CNT_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en_i,
  input  logic             s_pos_i,
  input  logic             c_pos_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             err_o
);
  localparam int unsigned STATES = 4 * PERIODS;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(STATES - 1);

  logic [1:0]       prev_q;
  logic [1:0]       cur_quad;
  qstep_e           step;
  logic             step_up, step_dn, step_bad;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             err_q;

  assign cur_quad = level_quadrant(s_pos_i, c_pos_i);
  assign step     = classify_step(prev_q, cur_quad);
  assign step_up  = step_en_i && (step == STEP_UP);
  assign step_dn  = step_en_i && (step == STEP_DOWN);
  assign step_bad = step_en_i && (step == STEP_BAD);

  always_comb begin
    cnt_nxt = cnt_q;
    if (step_up)      cnt_nxt = (cnt_q == CNT_TOP) ? '0 : cnt_q + 1'b1;
    else if (step_dn) cnt_nxt = (cnt_q == '0) ? CNT_TOP : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= 2'd0;
      err_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (step_en_i) prev_q <= cur_quad;
      if (step_bad)  err_q  <= 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_nxt;
  assign err_o     = err_q;

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP); // R4
  AST_LOW_BITS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    !err_q |-> (cnt_q[1:0] == prev_q)); // R3
  AST_BAD_STEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    step_bad |=> (cnt_q == $past(cnt_q)) && err_q); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R5
  AST_COUNT_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up || step_dn) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/sc_atan_fine.sv
module sc_atan_fine
  import sincos_pkg::*;
#(
  parameter int ADC_W  = 12,
  parameter int FINE_W = 10,
  parameter int IDX_W  = 6
) (
  input  logic signed [ADC_W-1:0] sin_i,
  input  logic signed [ADC_W-1:0] cos_i,
  output logic [1:0]              quad_o,
  output logic [FINE_W-1:0]       fine_o
);
  localparam int unsigned N    = 1 << IDX_W;
  localparam int unsigned HALF = 1 << (FINE_W - 1);
  localparam int NW = ADC_W + IDX_W;
  localparam logic [FINE_W:0]   FULL_V = 1 << FINE_W;
  localparam logic [FINE_W-1:0] FINE_TOP = '1;

  logic [FINE_W-1:0] lut [N+1];

  for (genvar g = 0; g <= N; g++) begin : g_lut
    assign lut[g] = FINE_W'(octant_entry(g, IDX_W, HALF));
  end

  logic [ADC_W-1:0] mag_s, mag_c, x, y;
  logic             s_neg, c_neg, s_zero, c_zero;
  logic [NW-1:0]    num, den, quo;
  logic [IDX_W:0]   idx;
  logic [FINE_W:0]  ext;

  always_comb begin
    s_neg  = sin_i[ADC_W-1];
    c_neg  = cos_i[ADC_W-1];
    s_zero = (sin_i == '0);
    c_zero = (cos_i == '0);
    mag_s  = s_neg ? ADC_W'(-sin_i) : ADC_W'(sin_i);
    mag_c  = c_neg ? ADC_W'(-cos_i) : ADC_W'(cos_i);
    if (!c_neg && !c_zero && !s_neg) begin
      quad_o = 2'd0; x = mag_c; y = mag_s;
    end else if (!s_neg && !s_zero) begin
      quad_o = 2'd1; x = mag_s; y = mag_c;
    end else if (c_neg) begin
      quad_o = 2'd2; x = mag_c; y = mag_s;
    end else if (s_neg) begin
      quad_o = 2'd3; x = mag_s; y = mag_c;
    end else begin
      quad_o = 2'd0; x = '0; y = '0;
    end

    if (y <= x) begin
      num = {y, {IDX_W{1'b0}}};
      den = NW'(x);
    end else begin
      num = {x, {IDX_W{1'b0}}};
      den = NW'(y);
    end
    quo = (den == '0) ? '0 : num / den;
    idx = quo[IDX_W:0];
    ext = FULL_V - {1'b0, lut[idx]};

    if (x == '0)     fine_o = '0;
    else if (y <= x) fine_o = lut[idx];
    else             fine_o = ext[FINE_W] ? FINE_TOP : ext[FINE_W-1:0];
  end

endmodule

// File: rtl/sincos_pos_eval.sv
module sincos_pos_eval
  import sincos_pkg::*;
#(
  parameter int ADC_W     = 12,
  parameter int GAIN_W    = 12,
  parameter int GAIN_FRAC = 10,
  parameter int FINE_W    = 10,
  parameter int IDX_W     = 6,
  parameter int PERIODS   = 1000,
  localparam int CNT_W    = $clog2(4 * PERIODS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smp_valid_i,
  input  logic signed [ADC_W-1:0]   sin_raw_i,
  input  logic signed [ADC_W-1:0]   cos_raw_i,
  input  logic signed [ADC_W-1:0]   sin_off_i,
  input  logic signed [ADC_W-1:0]   cos_off_i,
  input  logic        [GAIN_W-1:0]  sin_gain_i,
  input  logic        [GAIN_W-1:0]  cos_gain_i,
  output logic                      pos_valid_o,
  output logic [CNT_W-1:0]          count_o,
  output logic [FINE_W-1:0]         fine_o,
  output logic [CNT_W+FINE_W-1:0]   pos_o,
  output logic                      quad_err_o
);
  localparam logic [FINE_W-1:0] FINE_TOP = '1;

  logic signed [ADC_W-1:0] raw_a  [2];
  logic signed [ADC_W-1:0] off_a  [2];
  logic        [GAIN_W-1:0] gain_a [2];
  logic signed [ADC_W-1:0] corr_a [2];

  assign raw_a[0]  = sin_raw_i;
  assign raw_a[1]  = cos_raw_i;
  assign off_a[0]  = sin_off_i;
  assign off_a[1]  = cos_off_i;
  assign gain_a[0] = sin_gain_i;
  assign gain_a[1] = cos_gain_i;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    sc_corrector #(.ADC_W(ADC_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_corr (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid_i (smp_valid_i),
      .raw_i      (raw_a[ch]),
      .off_i      (off_a[ch]),
      .gain_i     (gain_a[ch]),
      .corr_o     (corr_a[ch])
    );
  end

  logic             stage1_q;
  logic             s_pos, c_pos;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             err_q;
  logic [1:0]       atan_quad;
  logic [FINE_W-1:0] atan_fine, fine_d, fine_q;
  logic [1:0]       quad_gap;
  logic             clamp_hi;
  logic             pos_valid_q;

  assign s_pos = (corr_a[0] > 0);
  assign c_pos = (corr_a[1] > 0);

  sc_quad_counter #(.PERIODS(PERIODS), .CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en_i (stage1_q),
    .s_pos_i   (s_pos),
    .c_pos_i   (c_pos),
    .cnt_o     (cnt_q),
    .cnt_nxt_o (cnt_nxt),
    .err_o     (err_q)
  );

  sc_atan_fine #(.ADC_W(ADC_W), .FINE_W(FINE_W), .IDX_W(IDX_W)) u_atan (
    .sin_i  (corr_a[0]),
    .cos_i  (corr_a[1]),
    .quad_o (atan_quad),
    .fine_o (atan_fine)
  );

  // reconcile the fine angle with the quadrant the counter settles on
  assign quad_gap = atan_quad - cnt_nxt[1:0];
  assign clamp_hi = (quad_gap == 2'd1);

  always_comb begin
    case (quad_gap)
      2'd0:    fine_d = atan_fine;
      2'd1:    fine_d = FINE_TOP;
      default: fine_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q    <= 1'b0;
      pos_valid_q <= 1'b0;
      fine_q      <= '0;
    end else begin
      stage1_q    <= smp_valid_i;
      pos_valid_q <= stage1_q;
      if (stage1_q) fine_q <= fine_d;
    end
  end

  assign pos_valid_o = pos_valid_q;
  assign count_o     = cnt_q;
  assign fine_o      = fine_q;
  assign pos_o       = {cnt_q, fine_q};
  assign quad_err_o  = err_q;

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_i |-> ##2 pos_valid_o); // R9
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !stage1_q |=> $stable(pos_o)); // R9
  AST_CLAMP_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (stage1_q && clamp_hi) |=> (fine_o == FINE_TOP)); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pos_valid_o |=> !pos_valid_o || $past(stage1_q)); // R9

endmodule

// File: tb/sincos_pos_eval_tb.sv
`timescale 1ns/1ps
module sincos_pos_eval_tb_top;
  localparam int ADC_W     = 12;
  localparam int GAIN_W    = 12;
  localparam int GAIN_FRAC = 10;
  localparam int FINE_W    = 10;
  localparam int IDX_W     = 6;
  localparam int PERIODS   = 5;
  localparam int CNT_W     = $clog2(4 * PERIODS);
  localparam int STATES    = 4 * PERIODS;
  localparam int NN        = 1 << IDX_W;
  localparam int HALF      = 1 << (FINE_W - 1);
  localparam int FULL      = 1 << FINE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [ADC_W-1:0] sin_raw = '0, cos_raw = '0, sin_off = '0, cos_off = '0;
  logic [GAIN_W-1:0] sin_gain = GAIN_W'(1024), cos_gain = GAIN_W'(1024);
  logic pos_valid, quad_err;
  logic [CNT_W-1:0] count;
  logic [FINE_W-1:0] fine;
  logic [CNT_W+FINE_W-1:0] pos;

  always #2.5 clk = ~clk;

  sincos_pos_eval #(.ADC_W(ADC_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .FINE_W(FINE_W),
                    .IDX_W(IDX_W), .PERIODS(PERIODS)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid),
    .sin_raw_i(sin_raw), .cos_raw_i(cos_raw), .sin_off_i(sin_off), .cos_off_i(cos_off),
    .sin_gain_i(sin_gain), .cos_gain_i(cos_gain),
    .pos_valid_o(pos_valid), .count_o(count), .fine_o(fine), .pos_o(pos), .quad_err_o(quad_err)
  );

  int n_tests = 0, n_fail = 0;
  int m_cnt, m_prev, m_fine;
  int m_err;
  int so_v = 0, co_v = 0, sg_v = 1024, cg_v = 1024;

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int tb_corr(input int raw, input int off, input int gain);
    int p, q, lim;
    lim = (1 << (ADC_W - 1)) - 1;
    p = (raw - off) * gain;
    q = p >>> GAIN_FRAC;
    if (q > lim) q = lim;
    if (q < -lim) q = -lim;
    return q;
  endfunction

  function automatic int tb_lut(input int i);
    return ((i * HALF) >> IDX_W) + ((89 * HALF * i * (NN - i)) >> (8 + 2 * IDX_W));
  endfunction

  // rotate (cos, sin) by -90 degrees until x>0 and y>=0
  task automatic tb_atan(input int s, input int c, output int q, output int f);
    int x, y, t, v;
    bit found;
    x = c; y = s; q = 0; found = 0;
    for (int k = 0; k < 4; k++) begin
      if (!found && x > 0 && y >= 0) begin q = k; found = 1; end
      if (!found) begin t = x; x = y; y = -t; end
    end
    if (!found) begin q = 0; f = 0; return; end
    if (y <= x) f = tb_lut((y * NN) / x);
    else begin
      v = FULL - tb_lut((x * NN) / y);
      f = (v > FULL - 1) ? FULL - 1 : v;
    end
  endtask

  function automatic int tb_level_quad(input int s, input int c);
    if (s > 0) return (c > 0) ? 0 : 1;
    return (c > 0) ? 3 : 2;
  endfunction

  task automatic model_step(input int rs, input int rc);
    int cs, cc, lq, d, aq, af, gap;
    cs = tb_corr(rs, so_v, sg_v);
    cc = tb_corr(rc, co_v, cg_v);
    lq = tb_level_quad(cs, cc);
    d = (lq - m_prev) & 3;
    if (d == 1) m_cnt = (m_cnt + 1) % STATES;
    else if (d == 3) m_cnt = (m_cnt + STATES - 1) % STATES;
    else if (d == 2) m_err = 1;
    m_prev = lq;
    tb_atan(cs, cc, aq, af);
    gap = (aq - m_cnt) & 3;
    if (gap == 0) m_fine = af;
    else if (gap == 1) m_fine = FULL - 1;
    else m_fine = 0;
  endtask

  task automatic set_cal(input int so, input int co, input int sg, input int cg);
    @(negedge clk);
    so_v = so; co_v = co; sg_v = sg; cg_v = cg;
    sin_off = ADC_W'(so); cos_off = ADC_W'(co);
    sin_gain = GAIN_W'(sg); cos_gain = GAIN_W'(cg);
  endtask

  task automatic apply(input int rs, input int rc, input string tag);
    @(negedge clk);
    sin_raw = ADC_W'(rs); cos_raw = ADC_W'(rc); smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    check({tag, " R9 no early valid"}, int'(pos_valid), 0);
    model_step(rs, rc);
    @(negedge clk);
    check({tag, " R9 valid at n+2"}, int'(pos_valid), 1);
    check({tag, " R3 R4 count"}, int'(count), m_cnt);
    check({tag, " R6 R7 fine"}, int'(fine), m_fine);
    check({tag, " R8 merged"}, int'(pos), m_cnt * FULL + m_fine);
    check({tag, " R5 error flag"}, int'(quad_err), m_err);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0; m_prev = 0; m_fine = 0; m_err = 0;
    @(negedge clk);
    check("R10 count after reset", int'(count), 0);
    check("R10 fine after reset", int'(fine), 0);
    check("R10 pos after reset", int'(pos), 0);
    check("R10 error after reset", int'(quad_err), 0);
    check("R10 valid after reset", int'(pos_valid), 0);
  endtask

  task automatic at_angle(input int mdeg, input int amp, input string tag);
    real rad;
    int rs, rc;
    rad = real'(mdeg) * 3.14159265358979 / 180000.0;
    rs = so_v + int'(real'(amp) * $sin(rad));
    rc = co_v + int'(real'(amp) * $cos(rad));
    apply(rs, rc, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int ang, seed_dummy;
    seed_dummy = int'($urandom(32'h5A17));
    do_reset();

    // R6: plain first-quadrant angles, unity calibration
    at_angle(20000, 1500, "q0 20deg");
    at_angle(45000, 1500, "q0 45deg");

    // R7: sine exactly zero with cosine positive -> counter says q3, clamp high
    apply(0, 1200, "R7 sin zero");
    // R7: cosine zero with sine negative -> top of quadrant 2
    apply(-900, 0, "R7 cos zero");
    apply(-800, 500, "back to q3");
    apply(300, 900, "back to q0");

    // R4: forward wrap across the top of the count range, then backward
    ang = 30000;
    for (int k = 0; k < 24; k++) begin ang += 90000; at_angle(ang, 1400, "R4 forward wrap"); end
    for (int k = 0; k < 26; k++) begin ang -= 90000; at_angle(ang, 1400, "R4 backward wrap"); end

    // R2 R3: random walk with offsets, unity gain
    set_cal(-150, 120, 1024, 1024);
    for (int k = 0; k < 150; k++) begin
      ang += int'($urandom_range(120000)) - 60000;
      at_angle(ang, 1300, "R2 R3 random walk");
    end

    // R1: random offset and gain per sample block
    for (int b = 0; b < 10; b++) begin
      set_cal(int'($urandom_range(400)) - 200, int'($urandom_range(400)) - 200,
              700 + int'($urandom_range(700)), 700 + int'($urandom_range(700)));
      for (int k = 0; k < 15; k++) begin
        ang += int'($urandom_range(100000)) - 50000;
        at_angle(ang, 1100, "R1 calibrated walk");
      end
    end

    // R1: saturation makes unequal raw values equal -> 45 degree fine angle
    do_reset();
    set_cal(0, 0, 2047, 2047);
    apply(1500, 1500, "R1 pre-sat");
    apply(2000, 1500, "R1 saturation");
    check("R1 saturated pair gives half", int'(fine), HALF);
    apply(-2000, 1800, "R1 negative saturation");

    // R5: jump across two quadrants, count held, flag sticky
    set_cal(0, 0, 1024, 1024);
    apply(600, 700, "R5 setup q0");
    apply(-600, -700, "R5 illegal step");
    apply(-650, -650, "R5 flag sticky");
    do_reset();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule